// File: doc/BRIEF.md
# Cartridge Bank Switch Register Decoder

This block sits on the write side of a game cartridge's processor bus. It watches each write strobe on a 16-bit address and 8-bit data bus, picks out the 2 KB window the address falls in, and updates one register. The registers are eight 1 KB pattern-table slots, four 1 KB nametable slots, three 8 KB program slots and a 15-bit interrupt counter preload with its enable flag. The outputs drive the memory mapping logic next door. Each pattern and nametable slot gives a page number and a flag that says whether the page is in ROM or in on-board RAM.

Data values from 0xE0 upward request RAM. A nametable slot honours that request every time. A pattern slot honours it only when the RAM enable for its half of the pattern space is set. Slots 0 to 3 use the low enable and slots 4 to 7 use the high enable. Both enables are loaded by a write to the single address 0xE800. The RAM/ROM choice of a pattern slot is fixed when that slot is written, so a later change to an enable leaves already-written slots as they are. Counting and interrupt timing, the memory arrays and the sound registers belong to other blocks.

The decoder is a small set of registers with no sequencing of its own. Every register updates on the clock edge at which its window is written.

Top module: `cart_bank_decoder`

## Requirements
- R1: After reset every page, bank, counter value, flag and RAM enable is zero, so ROM is selected in every slot.
- R2: A write with address bits 15:11 equal to 0b01010 (0x5000–0x57FF) loads counter bits 7:0 from the data. Counter bits 14:8 and the interrupt enable do not change.
- R3: A write in 0x5800–0x5FFF sets the interrupt enable from data bit 7 and loads counter bits 14:8 from data bits 6:0. Counter bits 7:0 do not change.
- R4: Pattern slot k (0..7) is written anywhere in the window at 0x8000 + k*0x800, and its page output takes the written data. Page k sits at bits 8k+7:8k of `pat_page_o`.
- R5: On a pattern write the slot's RAM flag (`pat_ram_o` bit k) is set only if the data is at least 0xE0 and the enable for its half is set: the low enable for slots 0–3, the high enable for slots 4–7. Otherwise the flag is cleared.
- R6: Only a write to address 0xE800 exactly loads the low enable from data bit 6 and the high enable from data bit 7. A slot keeps the flag it received when it was written, even after the enables change.
- R7: Nametable slot k (0..3) is written in the window at 0xC000 + k*0x800. Data below 0xE0 gives ROM page = data and flag 0. Any other value gives flag 1 and page = data bit 0, with the upper page bits zero.
- R8: Program slot k (0..2) is written in the window at 0xE000 + k*0x800 and holds the data as an 8 KB bank. Its 4 KB index output, 9 bits at bits 9k+8:9k, is twice that value.
- R9: Writes with the strobe low, and writes outside the listed windows (including 0x0000–0x4FFF, 0x6000–0x7FFF and 0xF800–0xFFFF), change no output.
- R10: A write elsewhere in 0xE800–0xEFFF updates program slot 1 only and leaves both RAM enables unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 16 | Write address |
| wdata | input | 8 | Write data |
| pat_page_o | output | 64 | Eight pattern slot pages, slot k at bits 8k+7:8k |
| pat_ram_o | output | 8 | Pattern slot RAM flags, bit k for slot k |
| nt_page_o | output | 32 | Four nametable slot pages, slot k at bits 8k+7:8k |
| nt_ram_o | output | 4 | Nametable slot RAM flags |
| prg_bank_o | output | 24 | Three program 8 KB bank numbers |
| prg_idx_o | output | 27 | Three program 4 KB indices, 9 bits each |
| irq_count_o | output | 15 | Interrupt counter preload value |
| irq_en_o | output | 1 | Interrupt enable flag |

## Verification
The assertions assume that `addr` and `wdata` are known and stable whenever `wr_en` is high at a clock edge, and that reset is asserted from the first edge. Under that assumption, at most one window strobe can fire per cycle and the outputs stay put when no write takes place. The bench drives every input to a known value at time zero and holds reset low over several edges. It changes inputs only on the falling edge and lowers the strobe after each single-cycle write. This way each rising edge sees a clean and complete write, or no write at all.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

    // Kind of 2 KB window that a write address falls into
    typedef enum logic [2:0] {
        WK_NONE,
        WK_IRQ_LO,
        WK_IRQ_HI,
        WK_PAT,
        WK_NT,
        WK_PRG
    } win_kind_e;

    // Window index is address bits 15:11
    localparam int WIN_SHIFT  = 11;
    localparam int WIN_IRQ_LO = 10;   // 0x5000
    localparam int WIN_IRQ_HI = 11;   // 0x5800
    localparam int WIN_PAT0   = 16;   // 0x8000
    localparam int WIN_NT0    = 24;   // 0xC000
    localparam int WIN_PRG0   = 28;   // 0xE000

    // Single address that also loads the pattern RAM enables
    localparam logic [15:0] CFG_ADDR = 16'hE800;

endpackage

// File: rtl/cbd_win_decode.sv
module cbd_win_decode
    import cbd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int N_PAT  = 8,
    parameter int N_NT   = 4,
    parameter int N_PRG  = 3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              irq_lo_we,
    output logic              irq_hi_we,
    output logic [N_PAT-1:0]  pat_we,
    output logic [N_NT-1:0]   nt_we,
    output logic [N_PRG-1:0]  prg_we,
    output logic              cfg_we
);

    int        win_i;
    win_kind_e kind;
    logic      grp_pat, grp_nt, grp_prg;

    // Classify the window
    always_comb begin
        win_i = int'(addr[ADDR_W-1:WIN_SHIFT]);
        kind  = WK_NONE;
        if (win_i == WIN_IRQ_LO)
            kind = WK_IRQ_LO;
        else if (win_i == WIN_IRQ_HI)
            kind = WK_IRQ_HI;
        else if (win_i >= WIN_PAT0 && win_i < WIN_PAT0 + N_PAT)
            kind = WK_PAT;
        else if (win_i >= WIN_NT0 && win_i < WIN_NT0 + N_NT)
            kind = WK_NT;
        else if (win_i >= WIN_PRG0 && win_i < WIN_PRG0 + N_PRG)
            kind = WK_PRG;
    end

    // Group strobes
    always_comb begin
        irq_lo_we = 1'b0;
        irq_hi_we = 1'b0;
        grp_pat   = 1'b0;
        grp_nt    = 1'b0;
        grp_prg   = 1'b0;
        unique case (kind)
            WK_IRQ_LO: irq_lo_we = wr_en;
            WK_IRQ_HI: irq_hi_we = wr_en;
            WK_PAT:    grp_pat   = wr_en;
            WK_NT:     grp_nt    = wr_en;
            WK_PRG:    grp_prg   = wr_en;
            default:   ;
        endcase
    end

    // Per-slot strobes
    for (genvar g = 0; g < N_PAT; g++) begin : g_pat
        assign pat_we[g] = grp_pat && (win_i == WIN_PAT0 + g);
    end
    for (genvar g = 0; g < N_NT; g++) begin : g_nt
        assign nt_we[g] = grp_nt && (win_i == WIN_NT0 + g);
    end
    for (genvar g = 0; g < N_PRG; g++) begin : g_prg
        assign prg_we[g] = grp_prg && (win_i == WIN_PRG0 + g);
    end

    assign cfg_we = wr_en && (addr == ADDR_W'(CFG_ADDR));

endmodule

// File: rtl/cbd_chr_slot.sv
module cbd_chr_slot #(
    parameter int              DATA_W       = 8,
    parameter logic [DATA_W-1:0] RAM_THRESH = 8'hE0,
    parameter bit              RAM_PAGE_LSB = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] data,
    input  logic              gate_en,
    output logic [DATA_W-1:0] page,
    output logic              ram
);

    logic              take_ram;
    logic [DATA_W-1:0] next_page;

    assign take_ram = (data >= RAM_THRESH) && gate_en;

    // Variant: RAM page narrowed to one bit, or kept as written
    if (RAM_PAGE_LSB) begin : g_lsb
        assign next_page = take_ram ? {{(DATA_W-1){1'b0}}, data[0]} : data;
    end else begin : g_full
        assign next_page = data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            ram  <= 1'b0;
        end else if (we) begin
            page <= next_page;
            ram  <= take_ram;
        end
    end

    // R5 (pattern, gated) and R7 (nametable, gate tied high)
    assert_ram_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ram == (($past(data) >= RAM_THRESH) && $past(gate_en)));

    assert_slot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(page) && $stable(ram));

endmodule

// File: rtl/cbd_irq_reg.sv
module cbd_irq_reg #(
    parameter int DATA_W = 8,
    parameter int IRQ_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] data,
    output logic [IRQ_W-1:0]  count,
    output logic              en
);

    localparam int HI_W = IRQ_W - DATA_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            en    <= 1'b0;
        end else if (lo_we) begin
            count[DATA_W-1:0] <= data;
        end else if (hi_we) begin
            count[IRQ_W-1:DATA_W] <= data[HI_W-1:0];
            en                    <= data[DATA_W-1];
        end
    end

    assert_irq_lo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> count[DATA_W-1:0] == $past(data)
                  && $stable(count[IRQ_W-1:DATA_W]) && $stable(en));

    assert_irq_hi_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> count[IRQ_W-1:DATA_W] == $past(data[HI_W-1:0])
                  && en == $past(data[DATA_W-1]) && $stable(count[DATA_W-1:0]));

endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder
    import cbd_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter int          N_PAT      = 8,
    parameter int          N_NT       = 4,
    parameter int          N_PRG      = 3,
    parameter int          IRQ_W      = 15,
    parameter logic [7:0]  RAM_THRESH = 8'hE0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [N_PAT*DATA_W-1:0]       pat_page_o,
    output logic [N_PAT-1:0]              pat_ram_o,
    output logic [N_NT*DATA_W-1:0]        nt_page_o,
    output logic [N_NT-1:0]               nt_ram_o,
    output logic [N_PRG*DATA_W-1:0]       prg_bank_o,
    output logic [N_PRG*(DATA_W+1)-1:0]   prg_idx_o,
    output logic [IRQ_W-1:0]              irq_count_o,
    output logic                          irq_en_o
);

    localparam int HALF_PAT  = N_PAT / 2;
    localparam int IDX_W     = DATA_W + 1;
    localparam int LO_EN_BIT = DATA_W - 2;
    localparam int HI_EN_BIT = DATA_W - 1;

    logic             irq_lo_we, irq_hi_we, cfg_we;
    logic [N_PAT-1:0] pat_we;
    logic [N_NT-1:0]  nt_we;
    logic [N_PRG-1:0] prg_we;
    logic             lo_en, hi_en;

    cbd_win_decode #(
        .ADDR_W(ADDR_W), .N_PAT(N_PAT), .N_NT(N_NT), .N_PRG(N_PRG)
    ) u_dec (
        .wr_en     (wr_en),
        .addr      (addr),
        .irq_lo_we (irq_lo_we),
        .irq_hi_we (irq_hi_we),
        .pat_we    (pat_we),
        .nt_we     (nt_we),
        .prg_we    (prg_we),
        .cfg_we    (cfg_we)
    );

    // Pattern RAM enables, loaded only at the exact config address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_en <= 1'b0;
            hi_en <= 1'b0;
        end else if (cfg_we) begin
            lo_en <= wdata[LO_EN_BIT];
            hi_en <= wdata[HI_EN_BIT];
        end
    end

    for (genvar g = 0; g < N_PAT; g++) begin : g_pat
        cbd_chr_slot #(
            .DATA_W(DATA_W), .RAM_THRESH(RAM_THRESH), .RAM_PAGE_LSB(1'b0)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (pat_we[g]),
            .data    (wdata),
            .gate_en ((g < HALF_PAT) ? lo_en : hi_en),
            .page    (pat_page_o[g*DATA_W +: DATA_W]),
            .ram     (pat_ram_o[g])
        );
    end

    for (genvar g = 0; g < N_NT; g++) begin : g_nt
        cbd_chr_slot #(
            .DATA_W(DATA_W), .RAM_THRESH(RAM_THRESH), .RAM_PAGE_LSB(1'b1)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (nt_we[g]),
            .data    (wdata),
            .gate_en (1'b1),
            .page    (nt_page_o[g*DATA_W +: DATA_W]),
            .ram     (nt_ram_o[g])
        );
    end

    for (genvar g = 0; g < N_PRG; g++) begin : g_prg
        logic [DATA_W-1:0] bank_q;
        always_ff @(posedge clk) begin
            if (!rst_n)         bank_q <= '0;
            else if (prg_we[g]) bank_q <= wdata;
        end
        assign prg_bank_o[g*DATA_W +: DATA_W] = bank_q;
        assign prg_idx_o[g*IDX_W +: IDX_W]    = {bank_q, 1'b0};

        assert_prg_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
            prg_we[g] |=> bank_q == $past(wdata));
    end

    cbd_irq_reg #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_we (irq_lo_we),
        .hi_we (irq_hi_we),
        .data  (wdata),
        .count (irq_count_o),
        .en    (irq_en_o)
    );

    // R9: at most one register group strobed per cycle
    assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_lo_we, irq_hi_we, pat_we, nt_we, prg_we}));

    // R10: enables move only on the exact config address
    assert_cfg_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(lo_en) && $stable(hi_en));

    // R6: config address also lies in program slot 1's window
    assert_cfg_in_slot1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> prg_we[1]);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pat_page_o) && $stable(pat_ram_o) && $stable(nt_page_o)
                   && $stable(nt_ram_o) && $stable(prg_bank_o)
                   && $stable(irq_count_o) && $stable(irq_en_o));

endmodule

// File: tb/cart_bank_decoder_bench.sv
`timescale 1ns/1ps
module cart_bank_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  wdata = 8'h0;

    logic [63:0] pat_page_o;
    logic [7:0]  pat_ram_o;
    logic [31:0] nt_page_o;
    logic [3:0]  nt_ram_o;
    logic [23:0] prg_bank_o;
    logic [26:0] prg_idx_o;
    logic [14:0] irq_count_o;
    logic        irq_en_o;

    always #10 clk = ~clk;

    cart_bank_decoder u_cart_bank_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pat_page_o(pat_page_o), .pat_ram_o(pat_ram_o),
        .nt_page_o(nt_page_o), .nt_ram_o(nt_ram_o),
        .prg_bank_o(prg_bank_o), .prg_idx_o(prg_idx_o),
        .irq_count_o(irq_count_o), .irq_en_o(irq_en_o)
    );

    int checks = 0;
    int failures = 0;

    // Bench model of the requirements
    logic [7:0]  m_pat [8];
    logic        m_pram[8];
    logic [7:0]  m_nt  [4];
    logic        m_nram[4];
    logic [7:0]  m_prg [3];
    logic [14:0] m_irq;
    logic        m_en, m_lo, m_hi;

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin m_pat[i] = 0; m_pram[i] = 0; end
        for (int i = 0; i < 4; i++) begin m_nt[i] = 0; m_nram[i] = 0; end
        for (int i = 0; i < 3; i++) m_prg[i] = 0;
        m_irq = 0; m_en = 0; m_lo = 0; m_hi = 0;
    endtask

    task automatic cmp(string ctx, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, ctx, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        logic [63:0] e_pp, e_np, e_pb, e_pi;
        logic [7:0]  e_pr;
        logic [3:0]  e_nr;
        e_pp = 0; e_np = 0; e_pb = 0; e_pi = 0; e_pr = 0; e_nr = 0;
        for (int i = 0; i < 8; i++) begin e_pp[i*8 +: 8] = m_pat[i]; e_pr[i] = m_pram[i]; end
        for (int i = 0; i < 4; i++) begin e_np[i*8 +: 8] = m_nt[i];  e_nr[i] = m_nram[i]; end
        for (int i = 0; i < 3; i++) begin
            e_pb[i*8 +: 8] = m_prg[i];
            e_pi[i*9 +: 9] = 9'(m_prg[i]) * 9'd2;
        end
        cmp(ctx, "R4 pattern pages", pat_page_o, e_pp);
        cmp(ctx, "R5 pattern ram flags", 64'(pat_ram_o), 64'(e_pr));
        cmp(ctx, "R7 nametable pages", 64'(nt_page_o), e_np);
        cmp(ctx, "R7 nametable ram flags", 64'(nt_ram_o), 64'(e_nr));
        cmp(ctx, "R8 program banks", 64'(prg_bank_o), e_pb);
        cmp(ctx, "R8 program 4k index", 64'(prg_idx_o), e_pi);
        cmp(ctx, "R2 R3 irq counter", 64'(irq_count_o), 64'(m_irq));
        cmp(ctx, "R3 irq enable", 64'(irq_en_o), 64'(m_en));
    endtask

    // One write, model update, then check after the capturing edge
    task automatic wr(string ctx, logic [15:0] a, logic [7:0] d);
        int w;
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        w = int'(a[15:11]);
        if (w == 10) m_irq[7:0] = d;
        else if (w == 11) begin m_irq[14:8] = d[6:0]; m_en = d[7]; end
        else if (w >= 16 && w <= 23) begin
            m_pat[w-16]  = d;
            m_pram[w-16] = (((w - 16) < 4) ? m_lo : m_hi) && (d >= 8'hE0);
        end else if (w >= 24 && w <= 27) begin
            m_nram[w-24] = (d >= 8'hE0);
            m_nt[w-24]   = (d >= 8'hE0) ? {7'h0, d[0]} : d;
        end else if (w >= 28 && w <= 30) begin
            m_prg[w-28] = d;
            if (a == 16'hE800) begin m_lo = d[6]; m_hi = d[7]; end
        end
        check_all(ctx);
    endtask

    initial begin
        logic [7:0] pat_vals[6];
        logic [15:0] outside[7];
        pat_vals = '{8'h00, 8'h5A, 8'hDF, 8'hE0, 8'hE9, 8'hFF};
        outside  = '{16'h0000, 16'h1234, 16'h4FFF, 16'h6000, 16'h7FFF, 16'hF800, 16'hFFFF};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // IRQ counter halves
        for (int v = 0; v < 256; v++) begin
            wr("R2 low byte", 16'h5000 | 16'((v * 7) & 16'h7FF), 8'(v));
            wr("R3 high bits", 16'h5800 | 16'((v * 11) & 16'h7FF), 8'(255 - v));
        end

        // Pattern slots under every enable combination
        for (int e = 0; e < 4; e++) begin
            wr("R6 set enables", 16'hE800, {e[1], e[0], 6'h05});
            for (int k = 0; k < 8; k++)
                for (int j = 0; j < 6; j++)
                    wr("R4 R5 pattern sweep",
                       16'h8000 + 16'(k * 16'h800) + 16'((j * 331 + k) & 16'h7FF),
                       pat_vals[j]);
        end

        // Flags persist across an enable change
        wr("R6 low enable on", 16'hE800, 8'h40);
        wr("R6 ram write slot0", 16'h8000, 8'hE7);
        wr("R6 high enable on", 16'hE800, 8'h80);
        wr("R6 ram write slot5", 16'hA800, 8'hF1);
        wr("R6 enables off", 16'hE800, 8'h00);
        wr("R6 slot1 after off", 16'h8800, 8'hE1);

        // Near-miss config addresses
        wr("R10 E801", 16'hE801, 8'hC0);
        wr("R10 slot2 after E801", 16'h9000, 8'hE2);
        wr("R10 EFFF", 16'hEFFF, 8'hC0);
        wr("R10 slot6 after EFFF", 16'hB000, 8'hFE);

        // Nametable sweep
        for (int k = 0; k < 4; k++)
            for (int d = 0; d < 256; d++)
                wr("R7 nametable sweep",
                   16'hC000 + 16'(k * 16'h800) + 16'((d * 13) & 16'h7FF), 8'(d));

        // Program sweep
        for (int k = 0; k < 3; k++)
            for (int d = 0; d < 256; d++)
                wr("R8 program sweep",
                   16'hE000 + 16'(k * 16'h800) + 16'((d * 5 + 1) & 16'h7FF), 8'(d));

        // Outside windows
        for (int i = 0; i < 7; i++) wr("R9 outside window", outside[i], 8'hFF);

        // Strobe low
        @(negedge clk);
        addr = 16'h8000; wdata = 8'hFF; wr_en = 1'b0;
        @(negedge clk);
        addr = 16'h5800;
        @(negedge clk);
        check_all("R9 strobe low");

        // Reset again
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check_all("R1 second reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule